// File: doc/BRIEF.md
# DSP ALU Condition Flag Unit

This block is the status path of a fixed-point DSP arithmetic unit with guard bits. Each valid operation takes two 32-bit signed operands and an opcode: compare, add, add-with-carry, subtract or subtract-with-borrow. The operands are sign-extended into a 40-bit datapath with 8 guard bits. The block forms the 40-bit result and updates a registered set of flags one clock after the strobe: negative, zero, overflow, greater-than, and a programmable condition bit.

A 3-bit condition-select input sets the meaning of the condition bit. It can mean carry/borrow, negative, zero, overflow, signed greater-than or signed greater-or-equal, and two codes are reserved. The signed comparison modes correct the sign with an over-range indication, which is the signed overflow of the full 40-bit operation. Add-with-carry and subtract-with-borrow take their carry or borrow in from the current condition bit. They always write their carry or borrow out back into that bit, whatever the select says. Compare subtracts operand 2 from operand 1 and changes only the flags.

Top module: `dsp_cond_flags`

## Requirements
- R1: After reset, the result and all five flags (dc, n, z, v, gt) are 0.
- R2: The result and flags change only on a rising clock edge where op_valid is 1. They hold their values on every other cycle, whatever the other inputs are.
- R3: Opcode 0 is compare, 1 is add, 2 is add-with-carry, 3 is subtract and 4 is subtract-with-borrow. Add and subtract write the 40-bit sign-extended sum or difference to result. Compare leaves result unchanged. Opcodes 5, 6 and 7 change neither the result nor any flag.
- R4: On every valid operation, n takes bit 39 of the 40-bit result and z is 1 exactly when all 40 bits are 0. For compare, the 40-bit result is operand 1 minus operand 2.
- R5: On every valid operation, v is 1 exactly when the true value of the operation lies outside the 32-bit signed range.
- R6: On every valid operation, gt equals NOT((n XOR over-range) OR z), where over-range is the 40-bit signed overflow. For compare, gt equals (signed src1 > signed src2).
- R7: For add, subtract and compare, condition-select 000 loads the carry out of bit 39 (add) or the borrow (subtract, compare) into dc. Select 001 loads n, 010 loads z and 011 loads v.
- R8: Condition-select 100 loads the greater-than value of R6 into dc. Select 101 loads NOT(n XOR over-range) into dc, which for compare equals (signed src1 >= signed src2).
- R9: Condition-select 110 and 111 load 0 into dc for add, subtract and compare.
- R10: Add-with-carry adds the current dc as its carry in and loads the carry out of bit 39 into dc, whatever the condition-select value.
- R11: Subtract-with-borrow subtracts the current dc as its borrow in and loads the borrow out of the 40-bit subtraction into dc, whatever the condition-select value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation strobe |
| op_code | input | 3 | Operation: 0 cmp, 1 add, 2 addc, 3 sub, 4 subc |
| cond_sel | input | 3 | Meaning of the condition bit |
| src1 | input | 32 | Signed operand 1 |
| src2 | input | 32 | Signed operand 2 |
| result | output | 40 | Registered guard-extended result |
| flag_dc | output | 1 | Programmable condition bit |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | 32-bit overflow flag |
| flag_gt | output | 1 | Signed greater-than flag |

## Verification
The sweep pairs the most-negative, most-positive, zero and near-boundary operand values with every opcode and select code. A design that took overflow from the 40-bit sign instead of the 32-bit range would leave v clear for 0x7FFFFFFF plus 1. Equal operands catch a greater-than flag that forgets the zero term. The chained carry and borrow operations take their input from the bit left by the previous vector, so a design that ignored the carry in, or let the select override it, would give an off-by-one result or a wrong dc. Reserved opcodes and idle cycles are interleaved, and a design that updated on them would lose the held state.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
    typedef enum logic [2:0] {
        OP_CMP  = 3'd0,
        OP_ADD  = 3'd1,
        OP_ADDC = 3'd2,
        OP_SUB  = 3'd3,
        OP_SUBC = 3'd4
    } alu_op_e;

    typedef enum logic [2:0] {
        CS_CARRY = 3'd0,
        CS_NEG   = 3'd1,
        CS_ZERO  = 3'd2,
        CS_OVF   = 3'd3,
        CS_GT    = 3'd4,
        CS_GE    = 3'd5,
        CS_RSV6  = 3'd6,
        CS_RSV7  = 3'd7
    } cond_sel_e;

    typedef struct packed {
        logic dc;
        logic n;
        logic z;
        logic v;
        logic gt;
    } flag_t;
endpackage

// File: rtl/dcf_arith.sv
module dcf_arith #(
    parameter int OP_W    = 32,
    parameter int GUARD_W = 8,
    localparam int DP_W   = OP_W + GUARD_W
) (
    input  logic [OP_W-1:0] src1,
    input  logic [OP_W-1:0] src2,
    input  logic            is_sub,
    input  logic            cb_in,
    output logic [DP_W-1:0] res,
    output logic            cb_out,
    output logic            over_range,
    output logic            ov_low
);
    logic [DP_W-1:0] a_ext;
    logic [DP_W-1:0] b_ext;
    logic [DP_W-1:0] b_op;
    logic            c_in;
    logic            c_out;

    // guard-bit sign extension
    genvar g;
    generate
        for (g = 0; g < DP_W; g++) begin : g_ext
            if (g < OP_W) begin : g_lo
                assign a_ext[g] = src1[g];
                assign b_ext[g] = src2[g];
            end else begin : g_hi
                assign a_ext[g] = src1[OP_W-1];
                assign b_ext[g] = src2[OP_W-1];
            end
        end
    endgenerate

    always_comb begin
        b_op = is_sub ? ~b_ext : b_ext;
        c_in = is_sub ? ~cb_in : cb_in;
        {c_out, res} = {1'b0, a_ext} + {1'b0, b_op} + {{DP_W{1'b0}}, c_in};
        cb_out     = is_sub ? ~c_out : c_out;
        over_range = (a_ext[DP_W-1] == b_op[DP_W-1]) && (res[DP_W-1] != a_ext[DP_W-1]);
        ov_low     = (a_ext[OP_W-1] == b_op[OP_W-1]) && (res[OP_W-1] != a_ext[OP_W-1]);
    end
endmodule

// File: rtl/dcf_flag_eval.sv
module dcf_flag_eval #(
    parameter int DP_W = 40
) (
    input  logic [DP_W-1:0] res,
    input  logic            over_range,
    input  logic            ov_low,
    output logic            neg,
    output logic            zero,
    output logic            ovf,
    output logic            sgt,
    output logic            sge
);
    logic sign_fixed;

    always_comb begin
        neg        = res[DP_W-1];
        zero       = (res == '0);
        ovf        = ov_low;
        sign_fixed = neg ^ over_range;
        sgt        = ~(sign_fixed | zero);
        sge        = ~sign_fixed;
    end
endmodule

// File: rtl/dcf_cond_sel.sv
module dcf_cond_sel
    import dcf_pkg::*;
(
    input  logic [2:0] sel,
    input  logic       force_cb,
    input  logic       cb,
    input  logic       neg,
    input  logic       zero,
    input  logic       ovf,
    input  logic       sgt,
    input  logic       sge,
    output logic       dc
);
    cond_sel_e mode;

    always_comb begin
        mode = cond_sel_e'(sel);
        if (force_cb) begin
            dc = cb;
        end else begin
            unique case (mode)
                CS_CARRY: dc = cb;
                CS_NEG:   dc = neg;
                CS_ZERO:  dc = zero;
                CS_OVF:   dc = ovf;
                CS_GT:    dc = sgt;
                CS_GE:    dc = sge;
                CS_RSV6,
                CS_RSV7:  dc = 1'b0;
                default:  dc = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/dsp_cond_flags.sv
module dsp_cond_flags
    import dcf_pkg::*;
#(
    parameter int OP_W    = 32,
    parameter int GUARD_W = 8,
    localparam int DP_W   = OP_W + GUARD_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            op_valid,
    input  logic [2:0]      op_code,
    input  logic [2:0]      cond_sel,
    input  logic [OP_W-1:0] src1,
    input  logic [OP_W-1:0] src2,
    output logic [DP_W-1:0] result,
    output logic            flag_dc,
    output logic            flag_n,
    output logic            flag_z,
    output logic            flag_v,
    output logic            flag_gt
);
    flag_t           flags_q, flags_d;
    logic [DP_W-1:0] res_q, res_d;
    alu_op_e         op;
    logic            known_op;
    logic            is_sub;
    logic            chained;
    logic            cb_in;
    logic [DP_W-1:0] sum;
    logic            cb_out, over_range, ov_low;
    logic            neg, zero, ovf, sgt, sge, dc_new;

    always_comb begin
        op       = alu_op_e'(op_code);
        known_op = (op_code <= 3'd4);
        is_sub   = (op == OP_CMP) || (op == OP_SUB) || (op == OP_SUBC);
        chained  = (op == OP_ADDC) || (op == OP_SUBC);
        cb_in    = chained & flags_q.dc;
    end

    dcf_arith #(.OP_W(OP_W), .GUARD_W(GUARD_W)) arith_i (
        .src1(src1), .src2(src2), .is_sub(is_sub), .cb_in(cb_in),
        .res(sum), .cb_out(cb_out), .over_range(over_range), .ov_low(ov_low)
    );

    dcf_flag_eval #(.DP_W(DP_W)) eval_i (
        .res(sum), .over_range(over_range), .ov_low(ov_low),
        .neg(neg), .zero(zero), .ovf(ovf), .sgt(sgt), .sge(sge)
    );

    dcf_cond_sel sel_i (
        .sel(cond_sel), .force_cb(chained), .cb(cb_out),
        .neg(neg), .zero(zero), .ovf(ovf), .sgt(sgt), .sge(sge), .dc(dc_new)
    );

    always_comb begin
        flags_d = flags_q;
        res_d   = res_q;
        if (op_valid && known_op) begin
            flags_d = '{dc: dc_new, n: neg, z: zero, v: ovf, gt: sgt};
            if (op != OP_CMP) res_d = sum;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= '0;
            res_q   <= '0;
        end else begin
            flags_q <= flags_d;
            res_q   <= res_d;
        end
    end

    assign result  = res_q;
    assign flag_dc = flags_q.dc;
    assign flag_n  = flags_q.n;
    assign flag_z  = flags_q.z;
    assign flag_v  = flags_q.v;
    assign flag_gt = flags_q.gt;
endmodule

// File: rtl/dcf_checker.sv
module dcf_checker #(
    parameter int OP_W    = 32,
    parameter int GUARD_W = 8,
    localparam int DP_W   = OP_W + GUARD_W
) (
    input logic            clk,
    input logic            rst_n,
    input logic            op_valid,
    input logic [2:0]      op_code,
    input logic [2:0]      cond_sel,
    input logic [OP_W-1:0] src1,
    input logic [OP_W-1:0] src2,
    input logic [DP_W-1:0] result,
    input logic            flag_dc,
    input logic            flag_n,
    input logic            flag_z,
    input logic            flag_v,
    input logic            flag_gt
);
    logic [4:0] fl;
    assign fl = {flag_dc, flag_n, flag_z, flag_v, flag_gt};

    a_r2_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> ($stable(fl) && $stable(result)));

    a_r3_reserved_op: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code > 3'd4) |=> ($stable(fl) && $stable(result)));

    a_r3_cmp_keeps_result: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 3'd0) |=> $stable(result));

    a_r4_cmp_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 3'd0) |=> (flag_z == ($past(src1) == $past(src2))));

    a_r6_cmp_gt: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 3'd0) |=> (flag_gt == ($signed($past(src1)) > $signed($past(src2)))));

    a_r8_cmp_ge: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 3'd0 && cond_sel == 3'd5)
        |=> (flag_dc == ($signed($past(src1)) >= $signed($past(src2)))));

    a_r9_reserved_sel: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op_code == 3'd0 || op_code == 3'd1 || op_code == 3'd3) && cond_sel[2:1] == 2'b11)
        |=> !flag_dc);

    a_r6_gt_not_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !(flag_gt && flag_z));
endmodule

bind dsp_cond_flags dcf_checker #(.OP_W(OP_W), .GUARD_W(GUARD_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .cond_sel(cond_sel), .src1(src1), .src2(src2), .result(result),
    .flag_dc(flag_dc), .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v),
    .flag_gt(flag_gt)
);

// File: tb/dsp_cond_flags_tb_top.sv
`timescale 1ns/1ps
module dsp_cond_flags_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [2:0]  op_code = '0;
    logic [2:0]  cond_sel = '0;
    logic [31:0] src1 = '0;
    logic [31:0] src2 = '0;
    logic [39:0] result;
    logic        flag_dc, flag_n, flag_z, flag_v, flag_gt;

    int  n_vec = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    logic [39:0] m_res;
    logic        m_dc, m_n, m_z, m_v, m_gt;

    always #2 clk = ~clk;

    dsp_cond_flags dut_i (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .cond_sel(cond_sel), .src1(src1), .src2(src2), .result(result),
        .flag_dc(flag_dc), .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v),
        .flag_gt(flag_gt)
    );

    function automatic logic [31:0] opnd(int k);
        case (k)
            0: return 32'h0000_0000;
            1: return 32'h0000_0001;
            2: return 32'h0000_0002;
            3: return 32'hFFFF_FFFF;
            4: return 32'hFFFF_FFFE;
            5: return 32'h7FFF_FFFF;
            6: return 32'h7FFF_FFFE;
            7: return 32'h8000_0000;
            8: return 32'h8000_0001;
            9: return 32'h1234_5678;
            10: return 32'hEDCB_A988;
            default: return 32'h4000_0000;
        endcase
    endfunction

    function automatic longint u40(longint x);
        return x & ((longint'(1) <<< 40) - 1);
    endfunction

    // R10 R11 R7 R8 R9: arithmetic model of the next state
    task automatic model(input int op, input int sel, input logic [31:0] x, input logic [31:0] y);
        longint a, b, r, ci;
        bit cb, ovr, n, z, v, gt, ge, dc;
        if (op > 4) return;
        a  = longint'($signed(x));
        b  = longint'($signed(y));
        ci = (op == 2 || op == 4) ? longint'(m_dc) : 0;
        if (op == 1 || op == 2) begin
            r  = a + b + ci;
            cb = ((u40(a) + u40(b) + ci) >>> 40) != 0;
        end else begin
            r  = a - b - ci;
            cb = u40(a) < (u40(b) + ci);
        end
        ovr = (r > (longint'(1) <<< 39) - 1) || (r < -(longint'(1) <<< 39));
        n   = ((u40(r) >>> 39) & 1) != 0;
        z   = u40(r) == 0;
        v   = (r > 64'sd2147483647) || (r < -64'sd2147483648);
        gt  = !((n ^ ovr) || z);
        ge  = !(n ^ ovr);
        case (sel)
            0: dc = cb;
            1: dc = n;
            2: dc = z;
            3: dc = v;
            4: dc = gt;
            5: dc = ge;
            default: dc = 1'b0;
        endcase
        if (op == 2 || op == 4) dc = cb;
        m_dc = dc; m_n = n; m_z = z; m_v = v; m_gt = gt;
        if (op != 0) m_res = 40'(u40(r));
    endtask

    function automatic string tag_of(int op, int sel, bit res_bad, bit nz_bad, bit v_bad, bit gt_bad);
        if (op > 4) return "R3";
        if (res_bad) return "R3";
        if (nz_bad) return "R4";
        if (v_bad) return "R5";
        if (gt_bad) return "R6";
        if (op == 2) return "R10";
        if (op == 4) return "R11";
        if (sel < 4) return "R7";
        if (sel < 6) return "R8";
        return "R9";
    endfunction

    task automatic compare(input string tag);
        logic [44:0] act, exp;
        act = {result, flag_dc, flag_n, flag_z, flag_v, flag_gt};
        exp = {m_res, m_dc, m_n, m_z, m_v, m_gt};
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s op=%0d sel=%0d src1=%h src2=%h actual=%h expected=%h",
                     tag, op_code, cond_sel, src1, src2, act, exp);
        end
    endtask

    initial begin
        m_res = '0; m_dc = 0; m_n = 0; m_z = 0; m_v = 0; m_gt = 0;
        repeat (3) @(negedge clk);
        compare("R1");                      // R1 reset state
        rst_n = 1'b1;
        for (int op = 0; op < 8; op++) begin
            for (int sel = 0; sel < 8; sel++) begin
                for (int i = 0; i < 12; i++) begin
                    for (int j = 0; j < 12; j++) begin
                        @(negedge clk);
                        op_valid = 1'b1;
                        op_code  = 3'(op);
                        cond_sel = 3'(sel);
                        src1     = opnd(i);
                        src2     = opnd(j);
                        begin
                            logic [39:0] pr;
                            logic [4:0]  pf;
                            pr = m_res;
                            pf = {m_dc, m_n, m_z, m_v, m_gt};
                            model(op, sel, src1, src2);
                            @(negedge clk);
                            compare(tag_of(op, sel, m_res != result,
                                           {m_n, m_z} != {flag_n, flag_z},
                                           m_v != flag_v, m_gt != flag_gt));
                            if (op > 4 && (pr != m_res || pf != {m_dc, m_n, m_z, m_v, m_gt}))
                                $display("model error");
                        end
                        // R2: idle cycle with disturbing inputs
                        op_valid = 1'b0;
                        op_code  = 3'd1;
                        cond_sel = 3'd0;
                        src1     = opnd((i + 5) % 12);
                        src2     = opnd((j + 7) % 12);
                        @(negedge clk);
                        compare("R2");
                    end
                end
            end
        end
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule